// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital half of a 16-bit successive-approximation converter. It runs from one externally supplied conversion clock, which may be free-running or stopped between samples. While idle, the block keeps the sample switch closed so the analog front end can acquire. A falling edge on the active-low start input opens the switch and begins a conversion. The controller then tests one bit per clock, starting at the most significant bit. It presents each trial word to the capacitive DAC and reads back a one-bit comparator decision. A busy flag covers the whole conversion. The finished code is stored in an output register.

Software or a host reads the stored code through a parallel port gated by active-low chip-select and read. A byte-select input chooses between the full word and the upper byte placed on the low eight lines. The output follows byte-select at once, so the host can hold read low and fetch both halves by toggling byte-select. The port has no valid/ready handshake. The result has exactly one producer event, the end of a conversion, and the busy flag marks when that event is pending. A host that waits for busy to fall never reads a stale word, and the port has no back-pressure to apply.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After synchronous reset (`rst_i` high at a clock edge): `busy_o` is 0, `sample_o` is 1, `dac_o` is 0, and the stored result is 0.
- R2: When `start_n_i` is high at one rising clock edge and low at the next while idle, that second edge sets `busy_o` to 1 and `dac_o` to 16'h8000.
- R3: On each conversion edge, the bit under test is kept if `cmp_i` is 1 (input at or above the DAC level) and cleared if `cmp_i` is 0. The next lower bit is then set to 1 in `dac_o`.
- R4: `busy_o` stays high for exactly 16 clocks and falls on the edge that resolves bit 0. On that edge the stored result takes the final code and `dac_o` returns to 0.
- R5: `sample_o` is 0 whenever `busy_o` is 1 and 1 otherwise.
- R6: The stored result changes only on the completing edge of a conversion. A read taken during a conversion returns the previous code.
- R7: A start falling edge seen while `busy_o` is 1 is ignored. This includes an edge on the final conversion clock. No second conversion follows it.
- R8: `data_oe_o` is 1 only when `cs_n_i` and `rd_n_i` are both 0. While `data_oe_o` is 0, `data_o` is all zeros.
- R9: During a read, `byte_sel_i`=0 puts result bits 15..0 on `data_o[15:0]`. `byte_sel_i`=1 puts result bits 15..8 on `data_o[7:0]` and zeros on `data_o[15:8]`. The output follows `byte_sel_i` combinationally while read is held low.
- R10: Holding `start_n_i` low starts only one conversion. A new conversion needs `start_n_i` to go high and then fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_n_i | input | 1 | Start strobe, active low, acts on its falling edge |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above the DAC level |
| cs_n_i | input | 1 | Chip-select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| byte_sel_i | input | 1 | 0: full word, 1: upper byte on low lines |
| busy_o | output | 1 | High during a conversion |
| sample_o | output | 1 | Sample switch closed (acquisition) |
| dac_o | output | 16 | Trial word to the capacitive DAC |
| data_o | output | 16 | Parallel read data |
| data_oe_o | output | 1 | Drive enable for the data lines |

## Verification
Two collisions are provoked. In the first, the start input falls on the very clock that resolves the last bit. The bench pulses start exactly 16 clocks after a conversion begins and checks that busy drops there and stays low, because that edge still belongs to the old conversion. In the second, a read held active through the completing edge must show the old code before the edge and the new code after it. The reference model predicts both outcomes and is compared on every clock.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned CODE_W = 16;
  localparam int unsigned HALF_W = 8;

  // one-hot with only the top bit set
  function automatic logic [CODE_W-1:0] top_bit();
    logic [CODE_W-1:0] v;
    v = '0;
    v[CODE_W-1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_n_i,
  output logic fall_o
);
  logic start_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) start_q <= 1'b1;
    else       start_q <= start_n_i;
  end

  assign fall_o = start_q & ~start_n_i;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int unsigned W = sar_pkg::CODE_W
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         fall_i,
  input  logic         cmp_i,
  output logic         busy_o,
  output logic [W-1:0] trial_o,
  output logic         done_o,
  output logic [W-1:0] word_o
);
  localparam logic [W-1:0] MSB_ONE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] probe_q, trial_q, kept;
  logic         busy_q;

  // decide the bit under test from the comparator
  assign kept = cmp_i ? trial_q : (trial_q & ~probe_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      probe_q <= '0;
      trial_q <= '0;
      busy_q  <= 1'b0;
    end else if (!busy_q) begin
      if (fall_i) begin
        busy_q  <= 1'b1;
        probe_q <= MSB_ONE;
        trial_q <= MSB_ONE;
      end
    end else if (probe_q[0]) begin
      busy_q  <= 1'b0;
      probe_q <= '0;
      trial_q <= '0;
    end else begin
      probe_q <= probe_q >> 1;
      trial_q <= kept | (probe_q >> 1);
    end
  end

  assign busy_o  = busy_q;
  assign trial_o = trial_q;
  assign done_o  = busy_q & probe_q[0];
  assign word_o  = kept;

  // R3
  probe_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_q |-> $countones(probe_q) == 1);
  // R3
  probe_walk_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && !probe_q[0]) |=> (busy_q && probe_q[W-2:0] == $past(probe_q[W-1:1])));
  // R2
  start_msb_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_q && fall_i) |=> (busy_q && trial_q == MSB_ONE));
  // R4
  finish_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> (!busy_q && trial_q == '0));
  // R7
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && !done_o && fall_i) |=> busy_q);
endmodule

// File: rtl/sar_result_port.sv
module sar_result_port #(
  parameter int unsigned W  = sar_pkg::CODE_W,
  parameter int unsigned BW = sar_pkg::HALF_W
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         cs_n_i,
  input  logic         rd_n_i,
  input  logic         byte_sel_i,
  output logic [W-1:0] data_o,
  output logic         oe_o
);
  logic [W-1:0] result_q;
  logic [W-1:0] view;

  always_ff @(posedge clk_i) begin
    if (rst_i)       result_q <= '0;
    else if (load_i) result_q <= word_i;
  end

  always_comb begin
    if (byte_sel_i) view = {{(W-BW){1'b0}}, result_q[W-1 -: BW]};
    else            view = result_q;
  end

  assign oe_o   = ~cs_n_i & ~rd_n_i;
  assign data_o = oe_o ? view : '0;

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> $stable(result_q));
  // R8
  quiet_lines_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cs_n_i || rd_n_i) |-> (data_o == '0));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int unsigned W  = sar_pkg::CODE_W,
  parameter int unsigned BW = sar_pkg::HALF_W
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         start_n_i,
  input  logic         cmp_i,
  input  logic         cs_n_i,
  input  logic         rd_n_i,
  input  logic         byte_sel_i,
  output logic         busy_o,
  output logic         sample_o,
  output logic [W-1:0] dac_o,
  output logic [W-1:0] data_o,
  output logic         data_oe_o
);
  logic         fall;
  logic         done;
  logic [W-1:0] word;

  sar_start_detect u_start (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_n_i (start_n_i),
    .fall_o    (fall)
  );

  sar_sequencer #(.W(W)) u_seq (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .fall_i  (fall),
    .cmp_i   (cmp_i),
    .busy_o  (busy_o),
    .trial_o (dac_o),
    .done_o  (done),
    .word_o  (word)
  );

  sar_result_port #(.W(W), .BW(BW)) u_port (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (done),
    .word_i     (word),
    .cs_n_i     (cs_n_i),
    .rd_n_i     (rd_n_i),
    .byte_sel_i (byte_sel_i),
    .data_o     (data_o),
    .oe_o       (data_oe_o)
  );

  assign sample_o = ~busy_o;

  // R5
  switch_open_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy_o) |-> !sample_o);
  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!busy_o && dac_o == '0));
endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
  localparam int W = 16;

  logic clk = 0, rst = 1, start_n = 1, cs_n = 1, rd_n = 1, byte_sel = 0;
  int   vin = 0;
  logic cmp, busy, sample, oe;
  logic [W-1:0] dac, data;
  int total = 0, bad = 0;

  assign cmp = (vin >= int'(dac));

  sar_conv_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .start_n_i(start_n), .cmp_i(cmp),
    .cs_n_i(cs_n), .rd_n_i(rd_n), .byte_sel_i(byte_sel),
    .busy_o(busy), .sample_o(sample), .dac_o(dac),
    .data_o(data), .data_oe_o(oe)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  bit m_sq = 1, m_busy = 0;
  int m_bit = 0, m_trial = 0, m_res = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_sq = 1; m_busy = 0; m_trial = 0; m_res = 0; m_bit = 0;
    end else begin
      bit f;
      f = m_sq && !start_n;
      m_sq = start_n;
      if (!m_busy) begin
        if (f) begin m_busy = 1; m_bit = W-1; m_trial = 1 << (W-1); end
      end else begin
        if (!(vin >= m_trial)) m_trial = m_trial & ~(1 << m_bit);
        if (m_bit == 0) begin
          m_res = m_trial; m_busy = 0; m_trial = 0;
        end else begin
          m_bit = m_bit - 1;
          m_trial = m_trial | (1 << m_bit);
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_data();
    if (cs_n || rd_n) return 0;
    return byte_sel ? (m_res >> 8) : m_res;
  endfunction

  always @(negedge clk) if (!rst) begin
    chk("R4 busy", busy, m_busy);
    chk("R5 sample", sample, !m_busy);
    chk("R3 dac", dac, m_trial);
    chk("R8 oe", oe, !cs_n && !rd_n);
    chk("R9 data", data, exp_data());
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start_n = 0; tick(1); start_n = 1;
  endtask

  task automatic read_word(string req, int exp);
    cs_n = 0; rd_n = 0; byte_sel = 0; #1;
    chk(req, data, exp);
    byte_sel = 1; #0.5;
    chk("R9 upper byte", data, exp >> 8);
    byte_sel = 0; tick(1);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic convert(int v);
    vin = v; pulse_start();
    #1 chk("R2 busy after start", busy, 1);
    tick(W + 1);
    chk("R4 idle after sixteen", busy, 0);
    read_word("R4 result", v);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3); rst = 0; #1;
    chk("R1 busy", busy, 0);
    chk("R1 sample", sample, 1);
    chk("R1 dac", dac, 0);
    tick(1);
    read_word("R1 result", 0);

    // R2 exact start edge
    vin = 16'h1234; start_n = 0; tick(1);
    chk("R2 dac msb", dac, 16'h8000);
    start_n = 1; tick(W + 1);
    read_word("R4 result 1234", 16'h1234);

    convert(0);
    convert(16'hFFFF);
    convert(16'h8000);
    convert(16'h7FFF);
    convert(16'hA5C3);

    // R6 read during conversion returns old code, held across completion
    vin = 16'h0F0F; pulse_start(); tick(4);
    cs_n = 0; rd_n = 0; #0.5;
    chk("R6 old code mid conversion", data, 16'hA5C3);
    tick(W);
    chk("R6 new code after completion", data, 16'h0F0F);
    byte_sel = 1; #0.5;
    chk("R9 byte follows select", data, 16'h0F);
    byte_sel = 0; cs_n = 1; rd_n = 1; tick(1);

    // R7 start while busy, including on the final edge
    vin = 16'h3C3C; pulse_start(); tick(3); pulse_start();
    tick(W - 5); pulse_start();
    chk("R7 idle after last edge start", busy, 0);
    tick(3);
    chk("R7 no second conversion", busy, 0);
    read_word("R7 result", 16'h3C3C);

    // R10 held start
    vin = 16'h00FF; start_n = 0; tick(40);
    chk("R10 single conversion", busy, 0);
    start_n = 1; tick(1);
    read_word("R10 result", 16'h00FF);

    // R8 partial selects
    cs_n = 1; rd_n = 0; #0.5;
    chk("R8 cs high", oe, 0);
    chk("R8 cs high data", data, 0);
    cs_n = 0; rd_n = 1; #0.5;
    chk("R8 rd high", oe, 0);
    cs_n = 1; tick(1);

    // R1 reset mid conversion
    vin = 16'h5555; pulse_start(); tick(5);
    rst = 1; tick(1); rst = 0; #0.5;
    chk("R1 busy after reset", busy, 0);
    chk("R1 dac after reset", dac, 0);
    tick(1);
    read_word("R1 result cleared", 0);

    tick(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule